// File: doc/BRIEF.md
# Hot-swap bus link controller

This block decides when a card's two-wire bus (data and clock) may be joined to a live backplane bus while the card is being plugged in. It watches two supplies through comparator outputs. Each supply has one flag for the upper, power-good threshold and one flag for the lower, power-fail threshold. The block also watches the digitized levels of the four bus lines: backplane data and clock, and card data and clock. From these it sequences a set of enables for the analog parts around it. The precharge enable biases the lines before the link is made. The link enable closes the bidirectional buffer path. The boost enable turns on the rising-edge current sources.

After both supplies are qualified, the block waits for a fixed enable period with precharge on. It then arms its detection. It makes the link once all four lines have stayed high for a whole idle window. It also makes the link early if a STOP is seen on the backplane while every line is high. Once made, the link stays until a supply fails. Both timing windows are counted in clock cycles. Every asynchronous input passes through a synchronizer chain before any logic uses it.

Top module: `hsw_link_ctrl`

## Requirements
- R1: The block stays in lockout (phase 2'b00) until both supplies have shown their upper-threshold flag, in either order. The phase leaves lockout on the 4th rising clock edge after the second flag is applied.
- R2: If either supply's lower-threshold flag drops, the block returns to lockout from any phase on the 4th rising edge. A supply whose upper flag drops while its lower flag stays high keeps its qualification. A supply failure that lands in the same cycle as a pending link wins, and no link is made.
- R3: In lockout, link_en, pre_en and boost_en are all 0.
- R4: After lockout the block holds the init phase (2'b01) for exactly ENABLE_CYC cycles with pre_en=1 and link_en=0. A backplane STOP during init does not shorten it or cause a link.
- R5: In the armed phase (2'b10), pre_en stays 1. The link phase (2'b11) is entered after all four lines have been high for IDLE_CYC consecutive synchronized cycles. When the lines are already high at arming, the armed phase lasts exactly IDLE_CYC cycles.
- R6: Any of the four lines going low in the armed phase restarts the idle count. The link then follows on the (IDLE_CYC+2)th rising edge after the last line returns high.
- R7: In the armed phase, backplane data rising while backplane clock stays high, with the card lines high, makes the link on the 3rd rising edge after the data release. Data rising while clock is low is not a STOP.
- R8: In the link phase, link_en=1 and pre_en=0. boost_en follows the synchronized acc_on input, and is 0 while acc_on is 0.
- R9: Once linked, the block stays linked whatever the bus lines do, for as long as both supplies stay qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_a_hi | input | 1 | Supply A above upper (good) threshold |
| sup_a_lo | input | 1 | Supply A above lower (fail) threshold |
| sup_b_hi | input | 1 | Supply B above upper (good) threshold |
| sup_b_lo | input | 1 | Supply B above lower (fail) threshold |
| bp_sda | input | 1 | Backplane data line level |
| bp_scl | input | 1 | Backplane clock line level |
| cd_sda | input | 1 | Card data line level |
| cd_scl | input | 1 | Card clock line level |
| acc_on | input | 1 | External permission for rising-edge boost |
| link_en | output | 1 | Close the backplane-to-card buffer path |
| pre_en | output | 1 | Enable line precharge |
| boost_en | output | 1 | Enable rising-edge accelerators |
| phase | output | 2 | 00 lockout, 01 init, 10 armed, 11 linked |

## Verification
Two events can decide the same state update. One is the idle window expiring, which would make the link. The other is a supply failure reaching the supply qualifier, which forces lockout. The bench releases a card line in the armed phase. It then drops a supply's lower flag exactly 28 edges later, so that both decisions fall on the 32nd edge. It judges the outcome by requiring that link_en never rises and that the phase settles in lockout. A separate case puts a backplane STOP inside the init period, to show that the early-link path waits for arming.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
   typedef enum logic [1:0] {
      PH_LOCK = 2'b00,
      PH_INIT = 2'b01,
      PH_ARM  = 2'b10,
      PH_LINK = 2'b11
   } hsw_phase_e;

   localparam int LINE_N    = 4;
   localparam int LN_BP_SDA = 0;
   localparam int LN_BP_SCL = 1;
   localparam int LN_CD_SDA = 2;
   localparam int LN_CD_SCL = 3;
   localparam int SUP_N     = 2;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsw_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hsw_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsw_supply_qual.sv
module hsw_supply_qual #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] above_hi,
   input  logic [N-1:0] above_lo,
   output logic         all_ok
);
   if (N < 1) begin : g_bad_n
      $error("hsw_supply_qual: N must be at least 1");
   end

   logic [N-1:0] good;

   for (genvar i = 0; i < N; i++) begin : g_sup
      // fail flag wins over good flag; between thresholds the state is held
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           good[i] <= 1'b0;
         else if (!above_lo[i]) good[i] <= 1'b0;
         else if (above_hi[i])  good[i] <= 1'b1;
      end

      // R2
      sup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !above_lo[i] |=> !good[i]);
      // R1
      sup_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(good[i]) |-> $past(above_hi[i]));
   end

   assign all_ok = &good;
endmodule

// File: rtl/hsw_win_timer.sv
module hsw_win_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("hsw_win_timer: LIMIT must be at least 1");
   end

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
endmodule

// File: rtl/hsw_stop_det.sv
module hsw_stop_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sda,
   input  logic scl,
   output logic stop
);
   logic sda_q, scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q <= 1'b0;
         scl_q <= 1'b0;
      end else begin
         sda_q <= sda;
         scl_q <= scl;
      end
   end

   // data rises while clock is high both before and after
   assign stop = sda && !sda_q && scl && scl_q;

   // R7
   stop_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |-> $past(scl) && !$past(sda));
endmodule

// File: rtl/hsw_link_ctrl.sv
module hsw_link_ctrl
   import hsw_pkg::*;
#(
   parameter int ENABLE_CYC  = 36000,
   parameter int IDLE_CYC    = 28000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sup_a_hi,
   input  logic       sup_a_lo,
   input  logic       sup_b_hi,
   input  logic       sup_b_lo,
   input  logic       bp_sda,
   input  logic       bp_scl,
   input  logic       cd_sda,
   input  logic       cd_scl,
   input  logic       acc_on,
   output logic       link_en,
   output logic       pre_en,
   output logic       boost_en,
   output logic [1:0] phase
);
   if (ENABLE_CYC < 1 || IDLE_CYC < 1) begin : g_bad_win
      $error("hsw_link_ctrl: window lengths must be at least one cycle");
   end

   localparam int SYNC_W = LINE_N + 2 * SUP_N + 1;
   localparam int ACC_IX = SYNC_W - 1;

   logic [SYNC_W-1:0] raw_in, syn;
   logic [LINE_N-1:0] line_s;
   logic [SUP_N-1:0]  hi_s, lo_s;
   logic              acc_s;
   logic              sup_ok, all_hi, init_done, idle_done, stop_seen;
   hsw_phase_e        st;

   assign raw_in = {acc_on, sup_b_lo, sup_a_lo, sup_b_hi, sup_a_hi,
                    cd_scl, cd_sda, bp_scl, bp_sda};

   hsw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign line_s = syn[LINE_N-1:0];
   assign hi_s   = syn[LINE_N +: SUP_N];
   assign lo_s   = syn[LINE_N+SUP_N +: SUP_N];
   assign acc_s  = syn[ACC_IX];
   assign all_hi = &line_s;

   hsw_supply_qual #(.N(SUP_N)) u_sup (
      .clk      (clk),
      .rst_n    (rst_n),
      .above_hi (hi_s),
      .above_lo (lo_s),
      .all_ok   (sup_ok)
   );

   hsw_win_timer #(.LIMIT(ENABLE_CYC)) u_init_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == PH_INIT),
      .done  (init_done)
   );

   hsw_win_timer #(.LIMIT(IDLE_CYC)) u_idle_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   ((st == PH_ARM) && all_hi),
      .done  (idle_done)
   );

   hsw_stop_det u_stop (
      .clk   (clk),
      .rst_n (rst_n),
      .sda   (line_s[LN_BP_SDA]),
      .scl   (line_s[LN_BP_SCL]),
      .stop  (stop_seen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st <= PH_LOCK;
      else if (!sup_ok) st <= PH_LOCK;
      else begin
         unique case (st)
            PH_LOCK: st <= PH_INIT;
            PH_INIT: if (init_done) st <= PH_ARM;
            PH_ARM:  if (all_hi && (idle_done || stop_seen)) st <= PH_LINK;
            PH_LINK: st <= PH_LINK;
            default: st <= PH_LOCK;
         endcase
      end
   end

   assign link_en  = (st == PH_LINK);
   assign pre_en   = (st == PH_INIT) || (st == PH_ARM);
   assign boost_en = link_en && acc_s;
   assign phase    = st;

   // R2
   fail_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_ok |=> st == PH_LOCK);
   // R1
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_LOCK) && !sup_ok |=> st == PH_LOCK);
   // R4
   init_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == PH_INIT |=> st != PH_LINK);
   // R5
   link_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> $past(all_hi) && $past(st == PH_ARM));
   // R9
   link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_LINK) && sup_ok |=> st == PH_LINK);
endmodule

// File: tb/sim_hsw_link_ctrl.sv
`timescale 1ns/1ps
module sim_hsw_link_ctrl;
   localparam int EN_C = 40;
   localparam int ID_C = 30;
   localparam int SYNC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sup_a_hi = 0, sup_a_lo = 0, sup_b_hi = 0, sup_b_lo = 0;
   logic bp_sda = 1, bp_scl = 1, cd_sda = 1, cd_scl = 1, acc_on = 1;
   logic link_en, pre_en, boost_en;
   logic [1:0] phase;

   int n_cmp = 0, n_bad = 0;
   bit fin = 0;

   always #2.5 clk = ~clk;

   hsw_link_ctrl #(.ENABLE_CYC(EN_C), .IDLE_CYC(ID_C), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n),
      .sup_a_hi(sup_a_hi), .sup_a_lo(sup_a_lo), .sup_b_hi(sup_b_hi), .sup_b_lo(sup_b_lo),
      .bp_sda(bp_sda), .bp_scl(bp_scl), .cd_sda(cd_sda), .cd_scl(cd_scl),
      .acc_on(acc_on), .link_en(link_en), .pre_en(pre_en), .boost_en(boost_en),
      .phase(phase)
   );

   // expected latencies derived from the requirements
   function automatic int lat_sup();  return SYNC + 2;  endfunction
   function automatic int lat_idle(); return ID_C + 2;  endfunction
   function automatic int lat_stop(); return SYNC + 1;  endfunction
   function automatic int exp_outs(int ph, bit acc);
      // {link, pre, boost}
      case (ph)
         0: return 0;
         1, 2: return 3'b010;
         default: return acc ? 3'b101 : 3'b100;
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_outs(string tag, bit acc);
      int act = {link_en, pre_en, boost_en};
      int exp = exp_outs(phase, acc);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic wait_phase(int p, int maxc, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (phase != 2'(p) && n < maxc);
   endtask

   task automatic count_phase(int p, output int n);
      n = 0;
      while (phase == 2'(p) && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic supplies(bit a, bit b);
      sup_a_hi = a; sup_a_lo = a; sup_b_hi = b; sup_b_lo = b;
   endtask

   task automatic to_armed();
      int n;
      supplies(1, 1);
      wait_phase(1, 20, n);
      wait_phase(2, EN_C + 10, n);
   endtask

   task automatic to_lock();
      int n;
      supplies(0, 0);
      wait_phase(0, 20, n);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int n;
      bit saw;
      void'($urandom(32'd5171));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      chk(phase == 2'b00, "R3 reset phase", phase, 0);
      chk_outs("R3 reset outputs", acc_on);

      // R1 supply A first
      sup_a_hi = 1; sup_a_lo = 1;
      repeat (20) @(negedge clk);
      chk(phase == 2'b00, "R1 A only stays locked", phase, 0);
      chk_outs("R3 lockout outputs", acc_on);
      sup_b_hi = 1; sup_b_lo = 1;
      wait_phase(1, 20, n);
      chk(n == lat_sup(), "R1 exit latency A-first", n, lat_sup());

      // R4 init length with a STOP inside it
      n = 0;
      while (phase == 2'b01 && n < 1000) begin
         if (n == 5) bp_sda = 0;
         if (n == 9) bp_sda = 1;
         if (n == 2) chk_outs("R4 init outputs", acc_on);
         n++;
         @(negedge clk);
      end
      chk(n == EN_C, "R4 init length", n, EN_C);
      chk(phase == 2'b10, "R4 armed after init", phase, 2);
      chk_outs("R5 armed outputs", acc_on);

      // R5 armed length with lines already high
      count_phase(2, n);
      chk(n == ID_C, "R5 idle window length", n, ID_C);
      chk(phase == 2'b11, "R5 linked", phase, 3);
      chk_outs("R8 linked outputs acc=1", 1);

      // R9 random bus traffic while linked
      saw = 0;
      for (int i = 0; i < 200; i++) begin
         {bp_sda, bp_scl, cd_sda, cd_scl} = 4'($urandom_range(0, 15));
         @(negedge clk);
         if (phase != 2'b11) saw = 1;
      end
      chk(!saw, "R9 link held under traffic", saw, 0);
      {bp_sda, bp_scl, cd_sda, cd_scl} = 4'hF;

      // R2 hysteresis: upper flag drops, lower stays
      sup_a_hi = 0;
      repeat (20) @(negedge clk);
      chk(phase == 2'b11, "R2 between thresholds keeps link", phase, 3);

      // R2 lower flag drops
      sup_a_lo = 0;
      wait_phase(0, 20, n);
      chk(n == lat_sup(), "R2 fail latency", n, lat_sup());
      chk_outs("R3 outputs after fail", acc_on);

      // R1 supply B first
      supplies(0, 0);
      repeat (5) @(negedge clk);
      sup_b_hi = 1; sup_b_lo = 1;
      repeat (20) @(negedge clk);
      chk(phase == 2'b00, "R1 B only stays locked", phase, 0);
      acc_on = 0;
      sup_a_hi = 1; sup_a_lo = 1;
      wait_phase(1, 20, n);
      chk(n == lat_sup(), "R1 exit latency B-first", n, lat_sup());
      wait_phase(2, EN_C + 10, n);

      // R6 random low pulses restart the idle count
      saw = 0;
      for (int k = 0; k < 6; k++) begin
         int ln = $urandom_range(0, 3);
         int lo = $urandom_range(1, 8);
         int gp = $urandom_range(0, ID_C / 2);
         case (ln)
            0: bp_sda = 0;
            1: bp_scl = 0;
            2: cd_sda = 0;
            default: cd_scl = 0;
         endcase
         repeat (lo) @(negedge clk);
         {bp_sda, bp_scl, cd_sda, cd_scl} = 4'hF;
         repeat (gp) @(negedge clk);
         if (phase != 2'b10) saw = 1;
      end
      chk(!saw, "R6 no link before full window", saw, 0);
      cd_sda = 0;
      repeat (3) @(negedge clk);
      cd_sda = 1;
      wait_phase(3, 200, n);
      chk(n == lat_idle(), "R6 link after restart", n, lat_idle());
      chk_outs("R8 boost off with acc low", 0);
      acc_on = 1;
      repeat (3) @(negedge clk);
      chk_outs("R8 boost follows acc", 1);

      // R7 backplane STOP links early
      to_lock();
      to_armed();
      repeat ($urandom_range(1, 10)) @(negedge clk);
      bp_sda = 0;
      repeat (4) @(negedge clk);
      bp_sda = 1;
      wait_phase(3, 200, n);
      chk(n == lat_stop(), "R7 stop link latency", n, lat_stop());

      // R7 data rising with clock low is not a STOP
      to_lock();
      to_armed();
      bp_scl = 0;
      @(negedge clk);
      bp_sda = 0;
      repeat (3) @(negedge clk);
      bp_sda = 1;
      repeat (3) @(negedge clk);
      bp_scl = 1;
      wait_phase(3, 200, n);
      chk(n == lat_idle(), "R7 non-stop waits idle window", n, lat_idle());

      // R2 collision: supply failure on the same edge as idle expiry
      to_lock();
      to_armed();
      cd_scl = 0;
      repeat (5) @(negedge clk);
      cd_scl = 1;
      repeat (lat_idle() - lat_sup()) @(negedge clk);
      sup_b_lo = 0;
      saw = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (link_en) saw = 1;
      end
      chk(!saw, "R2 failure beats idle expiry", saw, 0);
      chk(phase == 2'b00, "R2 collision ends in lockout", phase, 0);

      fin = 1;
      summary();
      $finish;
   end
endmodule